// File: doc/BRIEF.md
# Coprocessor Busy-Response Interface Controller

This block is the slave-side interface of a coprocessor that runs concurrently with a host processor. The host starts instructions by writing one of three registers. A command write starts a general operation. A condition write asks for a predicate evaluation. A save write asks for a context format word. The host then reads a 16-bit response register to learn what the coprocessor needs.

The coprocessor cannot queue a second command or condition write while a general operation is still computing. In that case it refuses the write and shows a busy response. The host is expected to handle its pending work and then restart the refused instruction from the beginning. The refused write leaves nothing behind. An accepted operation is modelled as a countdown. It has a compute phase of programmable length, followed by a writeback phase in which the coprocessor flag register, which is program-visible, is updated. Once the writeback phase has begun, busy is never produced.

Top module: `cop_busy_ctrl`

## Requirements
- R1: After reset, `respData` is 16'h0000, `stateAltered` is 0 and `flagsOut` is 0.
- R2: The response word carries the come-again flag in bit 15, the PC bit in bit 14 and a 5-bit function code in bits 12:8. Busy is come-again set with function code 4, so it reads as 16'h8400 with bit 14 copied from bit 15 of the refused write word.
- R3: A command or condition write during the compute phase is refused. The response becomes busy, no operation starts, no condition result is stored and `flagsOut` is unchanged.
- R4: A command write while idle is accepted. The write word holds the PC request in bit 15, the new flags in bits 14:7 and the compute length minus one in bits 6:0. The response is 16'h0100 for (bits 6:0)+1 cycles. It is then 16'h8200 for WB_CYCLES cycles, with `stateAltered` high and `flagsOut` equal to bits 14:7 from the first of those cycles. After that the response returns to 16'h0000.
- R5: Command and condition writes while `stateAltered` is high are dropped. No busy appears, the flags keep the committed value and no new operation starts.
- R6: A busy response is held until a cycle with `respRdEn` high, and that read clears it. If a refusal coincides with the read, busy stays set.
- R7: A condition write while idle is accepted. The response becomes 16'h0000 with bit 0 = `flagsOut[wr[2:0]] ^ wr[3]`.
- R8: A save write never produces busy. It shows 16'h0600 with bit 0 set when an operation was in progress at the time of the write. A pending busy takes precedence over this word. A read that finds no busy clears the save word.
- R9: A command or condition write while idle is accepted even if a busy response is still unread, and the acceptance clears busy.
- R10: Back-to-back refused writes each return busy, and the PC bit follows the most recent refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Write strobe for the command register (general category) |
| condWrEn | input | 1 | Write strobe for the condition register (conditional category) |
| saveWrEn | input | 1 | Write strobe for the save request (other category) |
| respRdEn | input | 1 | Host read of the response register |
| wrData | input | 16 | Write data shared by the three write strobes |
| respData | output | 16 | Response register contents |
| stateAltered | output | 1 | High while the accepted operation is writing program-visible state |
| flagsOut | output | 8 | Program-visible coprocessor flag register |

## Verification
A refusal and the first program-visible write can fall on the same clock edge. This happens when a command or condition write arrives on the last compute cycle. On that edge the flag register commits, `stateAltered` rises and busy becomes pending, all at once. The bench arranges this collision deliberately, and also puts a host read on the same edge as a refusal. It judges the result against a behavioural model that applies the read, the acceptance, the refusal and the save capture in a fixed order on every edge. It checks that busy, the new flags and the altered flag all appear in the following cycle.

// File: rtl/cop_busy_pkg.sv
package cop_busy_pkg;

  localparam int RESP_W   = 16;
  localparam int CA_POS   = 15;
  localparam int PC_POS   = 14;
  localparam int FN_LSB   = 8;
  localparam int FN_W     = 5;

  localparam logic [FN_W-1:0] FN_NULL      = 5'h00;
  localparam logic [FN_W-1:0] FN_RELEASE   = 5'h01;
  localparam logic [FN_W-1:0] FN_WRITEBACK = 5'h02;
  localparam logic [FN_W-1:0] FN_BUSY      = 5'h04;
  localparam logic [FN_W-1:0] FN_SAVEFMT   = 5'h06;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_COMPUTE   = 2'd1,
    PH_WRITEBACK = 2'd2
  } phase_e;

  typedef struct packed {
    logic acceptCmd;
    logic acceptCond;
    logic refuse;
    logic commit;
    logic saveCap;
  } strobe_t;

  function automatic logic [RESP_W-1:0] packResp(input logic ca, input logic pc,
                                                 input logic [FN_W-1:0] fn,
                                                 input logic [7:0] low);
    logic [RESP_W-1:0] w;
    w = '0;
    w[CA_POS] = ca;
    w[PC_POS] = pc;
    w[FN_LSB +: FN_W] = fn;
    w[7:0] = low;
    return w;
  endfunction

endpackage

// File: rtl/cop_busy_seq.sv
module cop_busy_seq
  import cop_busy_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int WB_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic             condWrEn,
  input  logic             saveWrEn,
  input  logic [LEN_W-1:0] lenField,
  output phase_e           phase,
  output strobe_t          strb
);

  localparam int LEN_MAX = 1 << LEN_W;
  localparam int CNT_MAX = (LEN_MAX > WB_CYCLES) ? LEN_MAX : WB_CYCLES;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] WB_LAST = CNT_W'(WB_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             cntZero;
  logic             wrAny;

  assign cntZero = (cnt == '0);
  assign wrAny   = cmdWrEn | condWrEn;

  // Decision logic: acceptance and refusal depend only on the registered phase.
  always_comb begin
    strb            = '0;
    strb.acceptCmd  = (phase == PH_IDLE) && cmdWrEn;
    strb.acceptCond = (phase == PH_IDLE) && !cmdWrEn && condWrEn;
    strb.refuse     = (phase == PH_COMPUTE) && wrAny;
    strb.commit     = (phase == PH_COMPUTE) && cntZero;
    strb.saveCap    = saveWrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (cmdWrEn) begin
            phase <= PH_COMPUTE;
            cnt   <= CNT_W'(lenField);
          end
        end
        PH_COMPUTE: begin
          if (cntZero) begin
            phase <= PH_WRITEBACK;
            cnt   <= WB_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WRITEBACK: begin
          if (cntZero) phase <= PH_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cop_busy_dp.sv
module cop_busy_dp
  import cop_busy_pkg::*;
#(
  parameter int FLAG_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  phase_e            phase,
  input  logic              respRdEn,
  input  logic              pcBit,
  input  logic [FLAG_W-1:0] flagField,
  input  logic [SEL_W-1:0]  condSel,
  input  logic              condInv,
  output logic [RESP_W-1:0] respData,
  output logic [FLAG_W-1:0] flagsOut
);

  logic [FLAG_W-1:0] flagReg;
  logic [FLAG_W-1:0] pendFlags;
  logic              busyPend;
  logic              busyPc;
  logic              saveShown;
  logic              saveAct;
  logic              condRes;
  logic              predicate;

  assign predicate = flagReg[condSel] ^ condInv;
  assign flagsOut  = flagReg;

  // Program-visible flag register and the captured operand of the accepted command.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg   <= '0;
      pendFlags <= '0;
    end else begin
      if (strb.acceptCmd) pendFlags <= flagField;
      if (strb.commit)    flagReg   <= pendFlags;
    end
  end

  // Response state: read clears first, then acceptance, then refusal, then save capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyPend  <= 1'b0;
      busyPc    <= 1'b0;
      saveShown <= 1'b0;
      saveAct   <= 1'b0;
      condRes   <= 1'b0;
    end else begin
      if (respRdEn) begin
        if (busyPend)       busyPend  <= 1'b0;
        else if (saveShown) saveShown <= 1'b0;
      end
      if (strb.acceptCmd) begin
        condRes   <= 1'b0;
        saveShown <= 1'b0;
        busyPend  <= 1'b0;
      end
      if (strb.acceptCond) begin
        condRes   <= predicate;
        saveShown <= 1'b0;
        busyPend  <= 1'b0;
      end
      if (strb.refuse) begin
        busyPend <= 1'b1;
        busyPc   <= pcBit;
      end
      if (strb.saveCap) begin
        saveShown <= 1'b1;
        saveAct   <= (phase != PH_IDLE);
      end
    end
  end

  always_comb begin
    if (busyPend) begin
      respData = packResp(1'b1, busyPc, FN_BUSY, 8'h00);
    end else if (saveShown) begin
      respData = packResp(1'b0, 1'b0, FN_SAVEFMT, {7'd0, saveAct});
    end else begin
      unique case (phase)
        PH_COMPUTE:   respData = packResp(1'b0, 1'b0, FN_RELEASE, 8'h00);
        PH_WRITEBACK: respData = packResp(1'b1, 1'b0, FN_WRITEBACK, 8'h00);
        default:      respData = packResp(1'b0, 1'b0, FN_NULL, {7'd0, condRes});
      endcase
    end
  end

endmodule

// File: rtl/cop_busy_ctrl.sv
module cop_busy_ctrl
  import cop_busy_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FLAG_W    = 8,
  parameter int WB_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic              condWrEn,
  input  logic              saveWrEn,
  input  logic              respRdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [RESP_W-1:0] respData,
  output logic              stateAltered,
  output logic [FLAG_W-1:0] flagsOut
);

  localparam int LEN_W = DATA_W - 1 - FLAG_W;
  localparam int SEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1;

  phase_e  phase;
  strobe_t strb;

  cop_busy_seq #(
    .LEN_W     (LEN_W),
    .WB_CYCLES (WB_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrEn  (cmdWrEn),
    .condWrEn (condWrEn),
    .saveWrEn (saveWrEn),
    .lenField (wrData[LEN_W-1:0]),
    .phase    (phase),
    .strb     (strb)
  );

  cop_busy_dp #(
    .FLAG_W (FLAG_W),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .phase     (phase),
    .respRdEn  (respRdEn),
    .pcBit     (wrData[DATA_W-1]),
    .flagField (wrData[DATA_W-2 -: FLAG_W]),
    .condSel   (wrData[SEL_W-1:0]),
    .condInv   (wrData[SEL_W]),
    .respData  (respData),
    .flagsOut  (flagsOut)
  );

  assign stateAltered = (phase == PH_WRITEBACK);

endmodule

// File: rtl/cop_busy_checker.sv
module cop_busy_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWrEn,
  input logic        condWrEn,
  input logic        saveWrEn,
  input logic        pcIn,
  input logic [15:0] respData
);

  logic isBusy;
  assign isBusy = respData[15] && (respData[13:8] == 6'h04);

  // R3: a busy word only appears after a command or condition write
  assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isBusy) |-> $past(cmdWrEn || condWrEn));

  // R2, R10: a write seen during compute returns busy carrying that write's PC bit
  assert_compute_refuse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (respData == 16'h0100 && (cmdWrEn || condWrEn)) |=>
      (respData[15:8] == {1'b1, $past(pcIn), 6'h04}));

  // R5: no busy once the writeback response has been shown
  assert_no_busy_after_alter_R5: assert property (@(posedge clk) disable iff (!rstN)
    (respData == 16'h8200) |=> !isBusy);

  // R4: an idle command write starts the compute phase next cycle
  assert_accept_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (respData[15:8] == 8'h00 && cmdWrEn && !saveWrEn) |=> (respData == 16'h0100));

  // R8: a save write alone never raises busy
  assert_save_no_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (saveWrEn && !cmdWrEn && !condWrEn && !isBusy) |=> !isBusy);

endmodule

bind cop_busy_ctrl cop_busy_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdWrEn  (cmdWrEn),
  .condWrEn (condWrEn),
  .saveWrEn (saveWrEn),
  .pcIn     (wrData[15]),
  .respData (respData)
);

// File: tb/cop_busy_ctrl_test.sv
module cop_busy_ctrl_test;

  localparam int WB = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrEn = 1'b0, condWrEn = 1'b0, saveWrEn = 1'b0, respRdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] respData;
  logic        stateAltered;
  logic [7:0]  flagsOut;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;
  string curReq = "R1";

  // behavioural reference state
  int mPhase, mCnt, mPend, mFlags, mBusy, mPc, mSave, mSaveAct, mCond;

  always #10 clk = ~clk;

  cop_busy_ctrl #(.DATA_W(16), .FLAG_W(8), .WB_CYCLES(WB)) uut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .condWrEn(condWrEn),
    .saveWrEn(saveWrEn), .respRdEn(respRdEn), .wrData(wrData),
    .respData(respData), .stateAltered(stateAltered), .flagsOut(flagsOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mPend = 0; mFlags = 0; mBusy = 0;
      mPc = 0; mSave = 0; mSaveAct = 0; mCond = 0;
    end else begin
      int ph;
      ph = mPhase;
      if (ph == 1) begin
        if (mCnt == 0) begin mPhase = 2; mCnt = WB - 1; mFlags = mPend; end
        else mCnt = mCnt - 1;
      end else if (ph == 2) begin
        if (mCnt == 0) mPhase = 0; else mCnt = mCnt - 1;
      end
      if (respRdEn) begin
        if (mBusy != 0) mBusy = 0;
        else if (mSave != 0) mSave = 0;
      end
      if (ph == 0 && cmdWrEn) begin
        mPhase = 1; mCnt = wrData & 16'h7f; mPend = (wrData >> 7) & 8'hff;
        mCond = 0; mSave = 0; mBusy = 0;
      end else if (ph == 0 && condWrEn) begin
        mCond = ((mFlags >> (wrData & 7)) & 1) ^ ((wrData >> 3) & 1);
        mSave = 0; mBusy = 0;
      end else if (ph == 1 && (cmdWrEn || condWrEn)) begin
        mBusy = 1; mPc = wrData[15];
      end
      if (saveWrEn) begin mSave = 1; mSaveAct = (ph != 0); end
    end
  end

  function automatic logic [15:0] modelResp();
    if (mBusy != 0) return 16'h8400 | (16'(mPc) << 14);
    if (mSave != 0) return 16'h0600 | 16'(mSaveAct);
    if (mPhase == 1) return 16'h0100;
    if (mPhase == 2) return 16'h8200;
    return 16'(mCond);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({curReq, " model resp"}, respData, modelResp());
      check({curReq, " model altered"}, {15'd0, stateAltered}, (mPhase == 2) ? 16'd1 : 16'd0);
      check({curReq, " model flags"}, {8'd0, flagsOut}, 16'(mFlags));
    end
  end

  task automatic cyc(input logic c, input logic d, input logic s, input logic r,
                     input logic [15:0] w);
    cmdWrEn = c; condWrEn = d; saveWrEn = s; respRdEn = r; wrData = w;
    @(negedge clk);
    cmdWrEn = 0; condWrEn = 0; saveWrEn = 0; respRdEn = 0; wrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 16'h0);
  endtask

  function automatic logic [15:0] cmdWord(input logic pc, input logic [7:0] f,
                                         input logic [6:0] lenM1);
    return {pc, f, lenM1};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset resp", respData, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 resp", respData, 16'h0000);
    check("R1 altered", {15'd0, stateAltered}, 16'd0);
    check("R1 flags", {8'd0, flagsOut}, 16'd0);

    // R4 accept, R3/R10 refusals, R2 encoding
    curReq = "R4";
    cyc(1, 0, 0, 0, cmdWord(0, 8'hA5, 7'd3));
    check("R4 accepted", respData, 16'h0100);
    curReq = "R3";
    cyc(1, 0, 0, 0, 16'h8000);
    check("R2 R3 busy pc set", respData, 16'hC400);
    curReq = "R10";
    cyc(0, 1, 0, 0, 16'h0000);
    check("R10 busy pc follows latest", respData, 16'h8400);
    check("R3 flags untouched", {8'd0, flagsOut}, 16'h0000);
    idle(1);
    check("R3 busy held", respData, 16'h8400);
    curReq = "R4";
    idle(1);
    check("R4 altered", {15'd0, stateAltered}, 16'd1);
    check("R4 flags committed", {8'd0, flagsOut}, 16'h00A5);
    curReq = "R6";
    cyc(0, 0, 0, 1, 16'h0);
    check("R6 read clears busy", respData, 16'h8200);
    curReq = "R5";
    cyc(1, 0, 0, 0, cmdWord(1, 8'hFF, 7'd1));
    check("R5 write dropped", respData, 16'h8200);
    idle(1);
    check("R5 done", respData, 16'h0000);
    check("R5 flags kept", {8'd0, flagsOut}, 16'h00A5);

    // R7 condition evaluation on flags A5
    curReq = "R7";
    cyc(0, 1, 0, 0, 16'h0000);
    check("R7 sel0", respData, 16'h0001);
    cyc(0, 1, 0, 0, 16'h0001);
    check("R7 sel1", respData, 16'h0000);
    cyc(0, 1, 0, 0, 16'h0009);
    check("R7 sel1 inverted", respData, 16'h0001);

    // R8 save, plus refusal colliding with commit
    curReq = "R8";
    cyc(0, 0, 1, 0, 16'h0);
    check("R8 idle save", respData, 16'h0600);
    cyc(0, 0, 0, 1, 16'h0);
    check("R8 read clears save", respData, 16'h0001);
    cyc(1, 0, 0, 0, cmdWord(0, 8'h3C, 7'd1));
    cyc(0, 0, 1, 0, 16'h0);
    check("R8 save active", respData, 16'h0601);
    curReq = "R3";
    cyc(0, 1, 0, 0, 16'h0000);
    check("R3 busy over save", respData, 16'h8400);
    check("R4 commit same edge", {8'd0, flagsOut}, 16'h003C);
    check("R4 altered same edge", {15'd0, stateAltered}, 16'd1);
    curReq = "R8";
    cyc(0, 0, 0, 1, 16'h0);
    check("R8 save after busy", respData, 16'h0601);
    cyc(0, 0, 0, 1, 16'h0);
    check("R8 save cleared", respData, 16'h8200);
    idle(2);

    // R6 read and refusal on the same edge
    curReq = "R6";
    cyc(1, 0, 0, 0, cmdWord(0, 8'h11, 7'd7));
    cyc(1, 0, 0, 0, 16'h8000);
    check("R6 busy", respData, 16'hC400);
    cyc(0, 1, 0, 1, 16'h0000);
    check("R6 refusal beats read", respData, 16'h8400);
    cyc(0, 0, 0, 1, 16'h0);
    check("R6 read clears", respData, 16'h0100);
    idle(12);

    // R9 restart while busy unread
    curReq = "R9";
    cyc(1, 0, 0, 0, cmdWord(0, 8'h42, 7'd2));
    cyc(1, 0, 0, 0, 16'h8000);
    idle(6);
    check("R9 busy still unread", respData, 16'hC400);
    cyc(1, 0, 0, 0, cmdWord(0, 8'h24, 7'd0));
    check("R9 restart accepted", respData, 16'h0100);
    idle(5);
    check("R9 flags", {8'd0, flagsOut}, 16'h0024);
    finish_run();
  end

endmodule